// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous host and one external 32K x 8 asynchronous static RAM whose data pins form a single shared bus. The host issues a single read or write with a request/ready handshake. The block turns that request into active-low chip enable, output enable and write enable strobes, a registered address and a tri-state data bus that is split into output, input and drive-enable signals. Every strobe is a flop output, so the memory sees glitch-free edges that line up with the clock.

Each interval the memory needs is a nanosecond parameter. At elaboration the block turns each one into a whole number of clock cycles by rounding up against the clock period parameter. The timing parameters default to the 55 ns speed grade. Writes use write enable to time the cycle: output enable stays high throughout and the data drivers switch on late. Every read is followed by a recovery gap that lasts as long as the memory's output turn-off time. The controller therefore never drives the bus while the memory could still be driving it. When the block is idle, chip enable stays high so that the memory sits in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: Between requests, mem_ce_n, mem_oe_n and mem_we_n are all 1, mem_dq_oe is 0 and host_ready is 1. This is also the state just after reset.
- R2: A read holds mem_ce_n and mem_oe_n at 0 and mem_we_n at 1 for exactly RD_CYC cycles. RD_CYC is the largest of ceil(T_RC/P), ceil(T_AA/P) and ceil(T_OE/P), which is 6 at the defaults (P = 10 ns).
- R3: The clock edge that raises mem_oe_n at the end of a read also loads mem_dq_in into rd_data. At that same edge rd_valid goes to 1 for one cycle, RD_CYC+1 negedge samples after the accepting edge. rd_data then holds its value until the next read.
- R4: A write holds mem_ce_n and mem_we_n at 0 for exactly WZ_CYC+DRV_CYC cycles, which is 6 at the defaults. mem_oe_n stays 1 for the whole write.
- R5: mem_dq_oe is 0 for the first WZ_CYC = ceil(T_WZ/P) cycles of mem_we_n low (3 at the defaults). It is then 1 for DRV_CYC cycles, where DRV_CYC is at least ceil(T_DW/P) (3 at the defaults). It falls at the same edge where mem_we_n rises, and it is never 1 while mem_we_n is 1.
- R6: After a read, mem_ce_n stays 1 and host_ready stays 0 for TURN_CYC = max(1, ceil(T_OHZ/P)) cycles after mem_oe_n rises (2 at the defaults). The next memory cycle can start no sooner than TURN_CYC+1 cycles after mem_oe_n rises.
- R7: A request is taken only at a clock edge where host_ready and req_valid are both 1. req_valid and the request fields presented while the block is busy have no effect, neither on the memory contents nor on the running cycle.
- R8: mem_addr changes only at the edge where mem_ce_n falls. It stays stable while mem_ce_n is 0 and equals the address that was accepted.
- R9: A write updates the addressed byte with the accepted req_wdata, and a later read of that address returns it. Untouched bytes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address of the request |
| req_wdata | input | 8 | Write data |
| host_ready | output | 1 | Block idle, request may be accepted |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse, rd_data updated |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data received from the memory |
| mem_dq_oe | output | 1 | Enable of the data bus drivers |

## Verification
The hardest case to reach from the ports is a request that arrives while the block is still busy: a host that behaves well never raises req_valid in the middle of a cycle. The stimulus does this on purpose. It pushes junk write requests during the busy cycles, then reads back the junk address and checks that the address bus did not move. The bench's memory model returns poison data until the access time has passed since output enable fell. A shortened read window therefore shows up as a wrong byte. Random reads and writes are mixed with directed ones: a write right after a read, a read right after a write, and accesses to the two extreme addresses.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_TURN,
      ST_WR_HIZ,
      ST_WR_DRV
   } seq_state_t;

   // whole clock cycles covering a nanosecond interval (rounded up)
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      return (ns + period - 1) / period;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             at_zero
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (count_q != '0) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign at_zero = (count_q == '0);

endmodule

// File: rtl/sram_host_latch.sv
module sram_host_latch #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_wdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_addr  <= '0;
         out_wdata <= '0;
      end else if (accept) begin
         out_addr  <= in_addr;
         out_wdata <= in_wdata;
      end
   end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= capture;
   end

   generate
      if (HOLD_RDATA) begin : g_hold
         // keep last captured byte until the next read completes
         always_ff @(posedge clk) begin
            if (!rst_n)       rdata <= '0;
            else if (capture) rdata <= bus_in;
         end
      end else begin : g_pulse
         // byte is only meaningful alongside rvalid
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= capture ? bus_in : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned T_RC_NS       = 55,
   parameter int unsigned T_AA_NS       = 55,
   parameter int unsigned T_OE_NS       = 30,
   parameter int unsigned T_OHZ_NS      = 20,
   parameter int unsigned T_WC_NS       = 55,
   parameter int unsigned T_WP_NS       = 40,
   parameter int unsigned T_WZ_NS       = 25,
   parameter int unsigned T_DW_NS       = 25,
   parameter bit          HOLD_RDATA    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              host_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   // ---------------- derived cycle counts ----------------
   localparam int unsigned RD_CYC   = umax(1, umax(umax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                                        ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                                                   ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)));
   localparam int unsigned TURN_CYC = umax(1, ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS));
   localparam int unsigned WZ_CYC   = umax(1, ns_to_cyc(T_WZ_NS, CLK_PERIOD_NS));
   localparam int unsigned WLO_MIN  = umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_WC_NS, CLK_PERIOD_NS));
   localparam int unsigned DRV_CYC  = umax(umax(1, ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)),
                                           (WLO_MIN > WZ_CYC) ? (WLO_MIN - WZ_CYC) : 1);
   localparam int unsigned CNT_MAX  = umax(umax(RD_CYC, TURN_CYC), umax(WZ_CYC, DRV_CYC));
   localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

   localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);
   localparam logic [CNT_W-1:0] LD_WZ   = CNT_W'(WZ_CYC - 1);
   localparam logic [CNT_W-1:0] LD_DRV  = CNT_W'(DRV_CYC - 1);

   // ---------------- elaboration checks ----------------
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_seq_ctrl: ADDR_W and DATA_W must be at least 1");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_clk
         $error("sram_seq_ctrl: CLK_PERIOD_NS must be at least 1");
      end
   endgenerate

   // ---------------- sequencing state ----------------
   seq_state_t       state_q, state_d;
   logic             cnt_load;
   logic [CNT_W-1:0] cnt_val;
   logic             cnt_zero;
   logic             accept;
   logic             rd_done;

   assign host_ready = (state_q == ST_IDLE);
   assign accept     = host_ready && req_valid;

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      rd_done  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               cnt_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WR_HIZ;
                  cnt_val = LD_WZ;
               end else begin
                  state_d = ST_READ;
                  cnt_val = LD_RD;
               end
            end
         end
         ST_READ: begin
            if (cnt_zero) begin
               rd_done  = 1'b1;
               state_d  = ST_TURN;
               cnt_load = 1'b1;
               cnt_val  = LD_TURN;
            end
         end
         ST_TURN: begin
            if (cnt_zero) state_d = ST_IDLE;
         end
         ST_WR_HIZ: begin
            if (cnt_zero) begin
               state_d  = ST_WR_DRV;
               cnt_load = 1'b1;
               cnt_val  = LD_DRV;
            end
         end
         ST_WR_DRV: begin
            if (cnt_zero) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   sram_phase_cnt #(.CNT_W(CNT_W)) u_phase_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .at_zero  (cnt_zero)
   );

   // ---------------- strobes, registered from next state ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_ce_n  <= !(state_d == ST_READ || state_d == ST_WR_HIZ || state_d == ST_WR_DRV);
         mem_oe_n  <= !(state_d == ST_READ);
         mem_we_n  <= !(state_d == ST_WR_HIZ || state_d == ST_WR_DRV);
         mem_dq_oe <= (state_d == ST_WR_DRV);
      end
   end

   // ---------------- host side data path ----------------
   sram_host_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .in_addr   (req_addr),
      .in_wdata  (req_wdata),
      .out_addr  (mem_addr),
      .out_wdata (mem_dq_out)
   );

   sram_rd_capture #(.DATA_W(DATA_W), .HOLD_RDATA(HOLD_RDATA)) u_rd_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (rd_done),
      .bus_in  (mem_dq_in),
      .rdata   (rd_data),
      .rvalid  (rd_valid)
   );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned T_OHZ_NS      = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_ready,
   input logic              rd_valid,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr
);

   localparam int unsigned TURN   = umax(1, ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS));
   localparam int unsigned GAP_W  = $clog2(TURN + 2) + 1;
   localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(TURN + 1);

   // cycles since output enable was last low, saturating
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (!rst_n)              gap_q <= GAP_SAT;
      else if (!mem_oe_n)      gap_q <= '0;
      else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
   end

   p_ready_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

   p_read_we_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_ce_n));

   p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_rd_with_oe_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $rose(mem_oe_n));

   p_write_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_ce_n));

   p_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_we_n);

   p_release_with_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_dq_oe) |-> $rose(mem_we_n));

   p_turn_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> (gap_q >= GAP_W'(TURN)));

   p_accept_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> $past(host_ready));

   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
   .ADDR_W        (ADDR_W),
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .T_OHZ_NS      (T_OHZ_NS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_ready (host_ready),
   .rd_valid   (rd_valid),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_dq_oe  (mem_dq_oe),
   .mem_addr   (mem_addr)
);

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

   localparam int P      = 10;
   localparam int T_RC   = 55;
   localparam int T_AA   = 55;
   localparam int T_OE   = 30;
   localparam int T_OHZ  = 20;
   localparam int T_WC   = 55;
   localparam int T_WP   = 40;
   localparam int T_WZ   = 25;
   localparam int T_DW   = 25;

   function automatic int cdiv(input int ns);
      return (ns + P - 1) / P;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int RD_CYC   = imax(1, imax(imax(cdiv(T_RC), cdiv(T_AA)), cdiv(T_OE)));
   localparam int TURN_CYC = imax(1, cdiv(T_OHZ));
   localparam int WZ_CYC   = imax(1, cdiv(T_WZ));
   localparam int DRV_CYC  = imax(imax(1, cdiv(T_DW)), imax(cdiv(T_WP), cdiv(T_WC)) - WZ_CYC);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        host_ready;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [14:0] mem_addr;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   always #5 clk = ~clk;

   sram_seq_ctrl u_sram_seq_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .host_ready (host_ready),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_dq_in  (mem_dq_in),
      .mem_dq_oe  (mem_dq_oe)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- memory model and shadow ----------------
   logic [7:0] mdl_mem[int];
   logic [7:0] shadow[int];

   function automatic logic [7:0] init_pat(input logic [14:0] a);
      return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
   endfunction
   function automatic logic [7:0] mdl_rd(input logic [14:0] a);
      return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : init_pat(a);
   endfunction
   function automatic logic [7:0] exp_rd(input logic [14:0] a);
      return shadow.exists(int'(a)) ? shadow[int'(a)] : init_pat(a);
   endfunction

   int mdl_k = 0;
   always @(negedge clk) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
         mdl_k = mdl_k + 1;
         // data appears only once access and enable times have elapsed
         if (mdl_k * P - P / 2 >= T_AA && mdl_k * P - P / 2 >= T_OE)
            mem_dq_in = mdl_rd(mem_addr);
         else
            mem_dq_in = 8'hEE;
      end else begin
         mdl_k     = 0;
         mem_dq_in = 8'hEE;
      end
      if (!mem_ce_n && !mem_we_n && mem_dq_oe)
         mdl_mem[int'(mem_addr)] = mem_dq_out;
   end

   // ---------------- timing monitors ----------------
   logic prv_ce = 1'b1, prv_oe = 1'b1, prv_we = 1'b1;
   int   oe_lo = 0, we_lo = 0, hiz = 0, drv = 0, gap = 0;
   bit   rd_bad = 0, wr_oe_bad = 0, addr_bad = 0, after_rd = 0, first_turn = 0;
   logic [14:0] cap_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         // R2 read window
         if (!mem_oe_n) begin
            oe_lo++;
            if (!mem_we_n || mem_ce_n) rd_bad = 1;
         end else if (!prv_oe) begin
            check(oe_lo == RD_CYC && !rd_bad, "R2 read window", oe_lo, RD_CYC);
            oe_lo = 0; rd_bad = 0;
            after_rd = 1; gap = 0; first_turn = 1;
         end
         // R4/R5 write window
         if (!mem_we_n) begin
            we_lo++;
            if (mem_dq_oe) drv++;
            else if (drv == 0) hiz++;
            if (!mem_oe_n || mem_ce_n) wr_oe_bad = 1;
         end else if (!prv_we) begin
            check(we_lo == WZ_CYC + DRV_CYC && !wr_oe_bad, "R4 write window", we_lo, WZ_CYC + DRV_CYC);
            check(hiz == WZ_CYC && drv == DRV_CYC && !mem_dq_oe, "R5 drive window", hiz * 16 + drv,
                  WZ_CYC * 16 + DRV_CYC);
            we_lo = 0; hiz = 0; drv = 0; wr_oe_bad = 0;
         end
         if (mem_we_n && mem_dq_oe) check(1'b0, "R5 drive outside write", 1, 0);
         // R6 turnaround
         if (after_rd && mem_ce_n) begin
            gap++;
            if (first_turn) begin
               check(!host_ready, "R6 ready low in turnaround", host_ready, 0);
               first_turn = 0;
            end
         end
         if (after_rd && !mem_ce_n && prv_ce) begin
            check(gap >= TURN_CYC + 1, "R6 turnaround gap", gap, TURN_CYC + 1);
            after_rd = 0;
         end
         // R8 address stability
         if (!mem_ce_n) begin
            if (prv_ce) cap_addr = mem_addr;
            else if (mem_addr != cap_addr) addr_bad = 1;
         end else if (!prv_ce) begin
            check(!addr_bad, "R8 address stable", int'(mem_addr), int'(cap_addr));
            addr_bad = 0;
         end
      end
      prv_ce = mem_ce_n; prv_oe = mem_oe_n; prv_we = mem_we_n;
   end

   // ---------------- host tasks ----------------
   task automatic wait_ready();
      while (!host_ready) @(negedge clk);
   endtask

   task automatic junk_while_busy();
      // R7: requests offered while busy must be ignored
      for (int i = 0; i < 2; i++) begin
         req_valid = 1'b1; req_write = 1'b1;
         req_addr  = 15'h1234; req_wdata = 8'hC3;
         @(negedge clk);
      end
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [14:0] a, input logic [7:0] d, input bit junk);
      wait_ready();
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      shadow[int'(a)] = d;
      if (junk) junk_while_busy();
   endtask

   task automatic do_read(input logic [14:0] a, input bit junk);
      int k;
      logic [7:0] e;
      e = exp_rd(a);
      wait_ready();
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a;
      k = 1;
      if (junk) begin
         junk_while_busy();
         k = 3;
      end
      while (!rd_valid && k < 40) begin
         @(negedge clk);
         k++;
      end
      check(k == RD_CYC + 1, "R3 read latency", k, RD_CYC + 1);
      check(rd_data == e, "R9 read data", rd_data, e);
      @(negedge clk);
      check(!rd_valid && rd_data == e, "R3 pulse and hold", {rd_valid, rd_data}, {1'b0, e});
   endtask

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && host_ready && !rd_valid,
            "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, host_ready},
            5'b11101);

      // directed corners
      do_read(15'h0000, 1'b0);
      do_write(15'h7FFF, 8'hFF, 1'b0);
      do_read(15'h7FFF, 1'b0);
      do_write(15'h0000, 8'h00, 1'b0);
      do_read(15'h0000, 1'b0);
      do_write(15'h0001, 8'hA5, 1'b0);   // write straight after read: R6 gap
      do_read(15'h0001, 1'b1);           // R7 junk during a read
      do_write(15'h0002, 8'h3C, 1'b1);   // R7 junk during a write
      do_read(15'h1234, 1'b0);           // R7 junk address untouched
      wait_ready();
      repeat (2) @(negedge clk);
      check(mem_ce_n && host_ready, "R1 idle standby", mem_ce_n, 1);

      // constrained random mix
      for (int n = 0; n < 300; n++) begin
         logic [14:0] a;
         logic [7:0]  d;
         a = ($urandom % 4 == 0) ? (15'h7FF0 | 15'($urandom % 16)) : 15'($urandom % 32);
         d = 8'($urandom);
         if ($urandom % 2) do_write(a, d, 1'b0);
         else              do_read(a, ($urandom % 8) == 0);
         if ($urandom % 5 == 0) repeat ($urandom % 3) @(negedge clk);
      end

      // R9 full sweep of touched locations
      for (int a = 0; a < 32; a++) do_read(15'(a), 1'b0);
      wait_ready();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule